// File: doc/BRIEF.md
# Half-Step Winding Sequencer

This block converts a step pulse and a direction level into drive commands for the two windings of a two-phase stepper running in half steps. A three-bit position register moves one place for every qualified rising edge on the step input: up when the direction input is high, down when it is low. The position wraps through eight states, and each state sets what each winding should do. A winding is either energised at the full set current or switched off. When it is energised, a polarity bit gives the sense of the current.

Both inputs pass through a multi-flop synchroniser, so the step and direction lines may be driven from an unrelated clock domain. A rising-edge detector turns each step pulse into exactly one count enable, however long the pulse is held. After every position change, each winding's output stage issues a one-clock resynchronisation pulse, so that the downstream constant-off-time current chopper restarts its blanking and off-time timers in step with the new drive pattern.

With a 2 MHz system clock and a 20 kHz step rate there are 100 clocks between steps, which is far more than the few cycles of latency the block adds.

Top module: `halfstep_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the position returns to 0. After release the outputs are `wind_en`=2'b01, `wind_dir`=2'b01 and `wind_resync`=2'b00. Bit 0 of each output vector is winding A and bit 1 is winding B.
- R2: Each rising edge of `step_in` causes exactly one position move, however long `step_in` stays high. The new drive values and the resync pulse appear after the (SYNC_STAGES+2)-th rising clock edge that follows the input edge, which is the 4th edge with default parameters.
- R3: When `dir_in` is 1 the position moves to (position+1) mod 8, and when it is 0 the position moves to (position-1) mod 8. This includes the wraps from 7 to 0 and from 0 to 7.
- R4: Winding A is enabled at every position except 2 and 6, and its polarity bit is 1 at positions 7, 0 and 1 and 0 at positions 3, 4 and 5. Winding B is enabled at every position except 0 and 4, and its polarity bit is 1 at positions 1, 2 and 3 and 0 at positions 5, 6 and 7. A disabled winding reports polarity 0. At least one winding is enabled at all times.
- R5: On every step, both `wind_resync` bits are high for exactly one clock cycle. That cycle is the first one in which the new `wind_en` and `wind_dir` values are present.
- R6: With no step edge, `wind_en`, `wind_dir` and the position stay constant, and `wind_resync` stays low.
- R7: Changes on `dir_in` when no step edge occurs have no effect on any output.
- R8: Asserting `rst` while the sequencer is running, from any position, brings the outputs back to the position-0 pattern of R1 without producing a resync pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_in | input | 1 | Step request; each rising edge moves one half step |
| dir_in | input | 1 | Direction: 1 counts the position up, 0 counts it down |
| wind_en | output | 2 | Per-winding amplitude enable (1 = set current, 0 = off); bit 0 = A, bit 1 = B |
| wind_dir | output | 2 | Per-winding current polarity for the chopper XOR; bit 0 = A, bit 1 = B |
| wind_resync | output | 2 | Per-winding one-cycle chopper timer restart; bit 0 = A, bit 1 = B |

## Verification
A long random walk of steps with random direction, random pulse widths and random gaps visits every position from both neighbours. This separates a correct decode table from one that is only right in one direction. Directed runs drive the walk down through 0 and up through 7 to expose wrap faults. They also hold `step_in` high for many cycles, which catches a level-sensitive edge detector, and toggle `dir_in` with no step, which catches direction leaking into the position. A reset in the middle of a run checks that the sequencer returns to position 0 from a non-zero state and that no spurious resync pulse follows.

// File: rtl/hs_pkg.sv
package hs_pkg;

   typedef struct packed {
      logic en;
      logic dir;
   } wind_cmd_t;

   // Half-step decode for one winding, indexed by that winding's own phase.
   // Phase 0 = positive full current; phases 2 and 6 = off.
   function automatic wind_cmd_t decode_phase(input logic [2:0] ph);
      wind_cmd_t c;
      c.en  = (ph != 3'd2) && (ph != 3'd6);
      c.dir = (ph == 3'd7) || (ph == 3'd0) || (ph == 3'd1);
      return c;
   endfunction

endpackage

// File: rtl/hs_step_sync.sv
module hs_step_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic step_in,
   input  logic dir_in,
   output logic adv,
   output logic adv_up
);
   logic [STAGES-1:0] stp_sh;
   logic [STAGES-1:0] dir_sh;
   logic              stp_old;

   always_ff @(posedge clk) begin
      if (rst) begin
         stp_sh  <= '0;
         dir_sh  <= '0;
         stp_old <= 1'b0;
      end else begin
         stp_sh  <= {stp_sh[STAGES-2:0], step_in};
         dir_sh  <= {dir_sh[STAGES-2:0], dir_in};
         stp_old <= stp_sh[STAGES-1];
      end
   end

   assign adv    = stp_sh[STAGES-1] & ~stp_old;
   assign adv_up = dir_sh[STAGES-1];

   // R2: the enable lasts one cycle per edge
   assert_single_enable_R2: assert property (@(posedge clk) disable iff (rst)
      adv |=> !adv);

endmodule

// File: rtl/hs_pos_counter.sv
module hs_pos_counter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic         up,
   output logic [W-1:0] pos
);
   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (adv)
         pos <= up ? pos + 1'b1 : pos - 1'b1;
   end

   assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
      (adv && up) |=> (pos == W'($past(pos) + 1'b1)));
   assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
      (adv && !up) |=> (pos == W'($past(pos) - 1'b1)));
   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(pos));

endmodule

// File: rtl/hs_phase_decoder.sv
module hs_phase_decoder
   import hs_pkg::*;
#(
   parameter int W      = 3,
   parameter int OFFSET = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pos,
   output logic         en,
   output logic         dir,
   output logic         resync
);
   localparam logic [W-1:0] OFS = W'(OFFSET);
   localparam wind_cmd_t    HOME = decode_phase(3'(0 - OFFSET));

   logic [W-1:0] ph;
   logic [W-1:0] pos_seen;
   wind_cmd_t    cmd;

   assign ph  = pos - OFS;
   assign cmd = decode_phase(ph[2:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         en       <= HOME.en;
         dir      <= HOME.dir;
         resync   <= 1'b0;
         pos_seen <= '0;
      end else begin
         en       <= cmd.en;
         dir      <= cmd.dir & cmd.en;
         resync   <= (pos != pos_seen);
         pos_seen <= pos;
      end
   end

   // R5: a position change yields a pulse on the next cycle, lasting one cycle
   assert_resync_on_change_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && pos != $past(pos)) |=> resync);
   assert_resync_single_R5: assert property (@(posedge clk) disable iff (rst)
      resync |=> !resync);
   // R4: a winding that is off reports polarity 0
   assert_off_polarity_R4: assert property (@(posedge clk) disable iff (rst)
      !en |-> !dir);

endmodule

// File: rtl/halfstep_sequencer.sv
module halfstep_sequencer #(
   parameter int SYNC_STAGES = 2,
   parameter int POS_W       = 3,
   parameter int NUM_WIND    = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step_in,
   input  logic                dir_in,
   output logic [NUM_WIND-1:0] wind_en,
   output logic [NUM_WIND-1:0] wind_dir,
   output logic [NUM_WIND-1:0] wind_resync
);
   localparam int WIND_SPACING = (1 << POS_W) / (2 * NUM_WIND);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (POS_W != 3) begin : g_bad_width
         $error("half-step decoding needs POS_W == 3");
      end
      if (NUM_WIND != 2) begin : g_bad_wind
         $error("NUM_WIND must be 2");
      end
   endgenerate

   logic             adv;
   logic             adv_up;
   logic [POS_W-1:0] pos;

   hs_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
      .adv(adv), .adv_up(adv_up));

   hs_pos_counter #(.W(POS_W)) u_cnt (
      .clk(clk), .rst(rst), .adv(adv), .up(adv_up), .pos(pos));

   for (genvar w = 0; w < NUM_WIND; w++) begin : g_wind
      hs_phase_decoder #(.W(POS_W), .OFFSET(w * WIND_SPACING)) u_dec (
         .clk(clk), .rst(rst), .pos(pos),
         .en(wind_en[w]), .dir(wind_dir[w]), .resync(wind_resync[w]));
   end

   // R4: never both windings off
   assert_winding_energised_R4: assert property (@(posedge clk) disable iff (rst)
      wind_en != '0);
   // R5: both windings restart their timers together
   assert_resync_together_R5: assert property (@(posedge clk) disable iff (rst)
      (wind_resync != '0) |-> (wind_resync == '1));

endmodule

// File: tb/sim_halfstep_sequencer.sv
`timescale 1ns/1ps
module sim_halfstep_sequencer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step_in = 1'b0;
   logic       dir_in = 1'b0;
   logic [1:0] wind_en, wind_dir, wind_resync;

   int checks = 0;
   int fails  = 0;
   int model_pos = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   halfstep_sequencer u0 (
      .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
      .wind_en(wind_en), .wind_dir(wind_dir), .wind_resync(wind_resync));

   // returns {en_b, en_a, dir_b, dir_a} for a position
   function automatic logic [3:0] exp_drive(input int p);
      case (p)
         0: return 4'b01_01;
         1: return 4'b11_11;
         2: return 4'b10_10;
         3: return 4'b11_10;
         4: return 4'b01_00;
         5: return 4'b11_00;
         6: return 4'b10_00;
         default: return 4'b11_01;
      endcase
   endfunction

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got en/dir/resync=%b expected %b (pos %0d)", req, act, exp, model_pos);
      end
   endtask

   task automatic check_state(input string req, input logic [1:0] rs);
      check(req, {wind_en, wind_dir, wind_resync}, {exp_drive(model_pos), rs});
   endtask

   // one step: rise, wait latency, check, hold, release, gap
   task automatic do_step(input bit up, input int hold, input int gap, input string req);
      @(negedge clk);
      dir_in  = up;
      step_in = 1'b1;
      model_pos = up ? (model_pos + 1) % 8 : (model_pos + 7) % 8;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check_state({req, " R2 R4 R5 new drive with resync"}, 2'b11);
      @(negedge clk);
      check_state("R5 resync one cycle", 2'b00);
      for (int i = 0; i < hold; i++) @(negedge clk);
      check_state("R2 held step gives no extra move", 2'b00);
      step_in = 1'b0;
      for (int i = 0; i < gap + 3; i++) @(negedge clk);
      check_state("R6 idle outputs stable", 2'b00);
   endtask

   initial begin
      void'($urandom(32'h5eed_0017));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_state("R1 reset state", 2'b00);

      // R3 wrap down 0 -> 7 and back up 7 -> 0
      do_step(1'b0, 0, 0, "R3 wrap down");
      do_step(1'b1, 0, 0, "R3 wrap up");
      // full cycle upward, then downward
      for (int i = 0; i < 8; i++) do_step(1'b1, 1, 1, "R3 up walk");
      for (int i = 0; i < 8; i++) do_step(1'b0, 1, 1, "R3 down walk");

      // R2 long held step
      do_step(1'b1, 40, 0, "R2 long hold");

      // R7 direction toggles without steps
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         dir_in = ~dir_in;
         repeat (3) @(negedge clk);
         check_state("R7 dir change ignored", 2'b00);
      end

      // random walk
      for (int i = 0; i < 150; i++)
         do_step(1'($urandom % 2), int'($urandom % 6), int'($urandom % 5), "R3 random");

      // R8 reset from non-zero position
      while (model_pos == 0) do_step(1'b1, 0, 0, "R3 pre-reset");
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_pos = 0;
      @(negedge clk);
      check_state("R8 mid-run reset", 2'b00);
      repeat (4) @(negedge clk);
      check_state("R8 no resync after reset", 2'b00);
      do_step(1'b1, 2, 2, "R8 step after reset");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule